// File: doc/BRIEF.md
# Page-Mode DRAM Burst Read Controller

This block fills one cache block from an asynchronous DRAM whose row and column addresses share one set of address pins. A single accepted request names a row and a starting column. The controller opens that row once and then reads four consecutive columns from it. It moves only the column strobe and the column address between words. Each word is captured from the DRAM data pins and returned with its beat number, and the final beat carries a last flag.

An elaboration-time switch picks the column cadence. The fast-page variant spends three cycles per later word and gives a 5-3-3-3 burst. The extended-data-out variant spends two cycles and gives 5-2-2-2, because the next column address goes onto the pins while the current word is still being held. After every row cycle the row strobe stays high for the precharge interval. A free-running timer schedules RAS-only refresh of successive rows. A refresh that falls due in the middle of a burst waits for that burst to finish and for precharge to elapse, and it goes ahead of any waiting request.

Top module: `dram_page_burst`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes and write enable are high (inactive), no response is valid, and the request port is ready.
- R2: The row address is on the address pins in the cycle the row strobe falls. The column address is on the pins in the cycle the column strobe falls. The four columns of a burst are start, start+1, start+2 and start+3, taken modulo 2^14.
- R3: The row strobe falls 1 cycle after the accepting edge. Beat 0 is returned LEAD_CYC cycles after the accepting edge.
- R4: In fast-page mode, beats are 3 cycles apart, so beat 3 arrives 14 cycles after acceptance. When the column strobe rises, the address pins still hold the current column.
- R5: In extended-data-out mode, beats are 2 cycles apart, so beat 3 arrives 11 cycles after acceptance. The next column address is already on the pins in the cycle the column strobe rises.
- R6: The row strobe stays low for the whole burst, LEAD_CYC + 3*beat - 1 cycles. Exactly four column strobe falls occur within it, and the column strobe is low only while the row strobe is low.
- R7: Each response is valid for one cycle. It carries the word present on the data pins at capture, a beat index 0..3 in order, and a last flag set only on beat 3.
- R8: Between any two row activations, the row strobe is high for at least PRE_CYC+1 cycles. A request that is already waiting is accepted PRE_CYC cycles after the edge that ends the previous burst.
- R9: With no traffic, refresh k (counting from 1) drops the row strobe k*REF_INTERVAL+2 cycles after reset. A refresh holds the row strobe low for LEAD_CYC-1 cycles with no column strobe. Refreshed rows count up from 0.
- R10: While a refresh is due or running, the request port is not ready. A request waiting during a refresh that started at edge S is accepted at edge S+LEAD_CYC+PRE_CYC.
- R11: A refresh that comes due during a burst starts PRE_CYC cycles after the burst's last capture edge, which puts its row strobe fall at that edge + PRE_CYC + 1.
- R12: Write enable stays high through every read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Block read request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_row | input | ADDR_W | Row of the block |
| req_col | input | ADDR_W | First column of the burst |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W | Shared row/column address pins |
| dram_dq | input | DATA_W | DRAM data pins |
| rsp_valid | output | 1 | Captured word valid |
| rsp_data | output | DATA_W | Captured word |
| rsp_beat | output | log2(BURST_LEN) | Beat index of the word |
| rsp_last | output | 1 | Final beat of the burst |

## Verification
Every result is tied to the edge that accepted the request. The row strobe falls one edge later. Beat k is due LEAD_CYC + k*beat edges later, and its column strobe falls one edge before that. The next waiting request is taken PRE_CYC edges after the last capture. Idle refreshes fall at fixed multiples of the interval plus two. The bench counts edges from reset release, records the cycle stamp of every strobe edge and response at the falling clock edge, and compares those stamps with the arithmetic above for both cadence variants side by side. Deferral is tested by aiming one request at an active refresh and another so that the refresh timer expires in mid-burst.

// File: rtl/dram_page_burst.sv
module dram_page_burst #(
  parameter int ADDR_W       = 14,
  parameter int DATA_W       = 16,
  parameter int BURST_LEN    = 4,
  parameter bit EDO_MODE     = 1'b0,
  parameter int LEAD_CYC     = 5,
  parameter int FPM_BEAT_CYC = 3,
  parameter int EDO_BEAT_CYC = 2,
  parameter int PRE_CYC      = 3,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_row,
  input  logic [ADDR_W-1:0]            req_col,
  output logic                         dram_ras_n,
  output logic                         dram_cas_n,
  output logic                         dram_we_n,
  output logic [ADDR_W-1:0]            dram_addr,
  input  logic [DATA_W-1:0]            dram_dq,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_data,
  output logic [$clog2(BURST_LEN)-1:0] rsp_beat,
  output logic                         rsp_last
);
  localparam int BEAT_CYC = EDO_MODE ? EDO_BEAT_CYC : FPM_BEAT_CYC;
  localparam int BW       = $clog2(BURST_LEN);
  localparam int WT_W     = $clog2(LEAD_CYC + BEAT_CYC);
  localparam int PC_W     = $clog2(PRE_CYC + 1);
  localparam int TM_W     = $clog2(REF_INTERVAL + 1);

  localparam logic [WT_W-1:0] WT_LEAD = WT_W'(LEAD_CYC - 1);
  localparam logic [WT_W-1:0] WT_BEAT = WT_W'(BEAT_CYC - 1);
  localparam logic [WT_W-1:0] WT_ADDR = WT_W'(2);
  localparam logic [WT_W-1:0] WT_STRB = WT_W'(1);
  localparam logic [PC_W-1:0] PC_INIT = PC_W'(PRE_CYC - 1);
  localparam logic [TM_W-1:0] TM_LAST = TM_W'(REF_INTERVAL - 1);
  localparam logic [BW-1:0]   LAST_B  = BW'(BURST_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_REFR, S_PRE} state_t;

  state_t            st;
  logic [WT_W-1:0]   wt;
  logic [PC_W-1:0]   pc;
  logic [BW-1:0]     beat;
  logic [ADDR_W-1:0] col_base;
  logic [ADDR_W-1:0] ref_row;
  logic [TM_W-1:0]   tmr;
  logic              ref_pend;
  logic [ADDR_W-1:0] col_cur;

  assign col_cur   = col_base + ADDR_W'(beat);
  assign req_ready = (st == S_IDLE) && !ref_pend;
  assign dram_we_n = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr      <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (st == S_IDLE && ref_pend) ref_pend <= 1'b0;
      if (tmr == TM_LAST) begin
        tmr      <= '0;
        ref_pend <= 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wt         <= '0;
      pc         <= '0;
      beat       <= '0;
      col_base   <= '0;
      ref_row    <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_addr  <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_beat   <= '0;
      rsp_last   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            st        <= S_REFR;
            dram_addr <= ref_row;
            wt        <= WT_LEAD;
          end else if (req_valid) begin
            st        <= S_READ;
            dram_addr <= req_row;
            col_base  <= req_col;
            beat      <= '0;
            wt        <= WT_LEAD;
          end
        end
        S_REFR: begin
          wt <= wt - 1'b1;
          if (wt == WT_LEAD) dram_ras_n <= 1'b0;
          if (wt == '0) begin
            dram_ras_n <= 1'b1;
            ref_row    <= ref_row + 1'b1;
            pc         <= PC_INIT;
            st         <= S_PRE;
          end
        end
        S_READ: begin
          wt <= wt - 1'b1;
          if (beat == '0 && wt == WT_LEAD) dram_ras_n <= 1'b0;
          if (beat == '0 && wt == WT_ADDR) dram_addr <= col_cur;
          if (!EDO_MODE && beat != '0 && wt == WT_BEAT) dram_addr <= col_cur;
          if (wt == WT_STRB) dram_cas_n <= 1'b0;
          if (wt == '0) begin
            dram_cas_n <= 1'b1;
            rsp_valid  <= 1'b1;
            rsp_data   <= dram_dq;
            rsp_beat   <= beat;
            rsp_last   <= (beat == LAST_B);
            if (beat == LAST_B) begin
              dram_ras_n <= 1'b1;
              pc         <= PC_INIT;
              st         <= S_PRE;
            end else begin
              beat <= beat + 1'b1;
              wt   <= WT_BEAT;
              if (EDO_MODE) dram_addr <= col_cur + 1'b1;
            end
          end
        end
        S_PRE: begin
          if (pc <= PC_W'(1)) st <= S_IDLE;
          else pc <= pc - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dram_page_burst_chk #(
  parameter int ADDR_W  = 14,
  parameter int PRE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_row,
  input logic              ras_n,
  input logic              cas_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rsp_valid,
  input logic              rsp_last
);
  localparam int HW = $clog2(PRE_CYC + 2) + 1;
  localparam logic [HW-1:0] HI_MIN = HW'(PRE_CYC + 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= HI_MIN;
    else if (!ras_n) hi_cnt <= '0;
    else if (hi_cnt < HI_MIN) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ras_n && addr == $past(req_row)));

  assert_col_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(addr));

  assert_row_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 !ras_n);

  assert_cas_in_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> (ras_n && !$past(ras_n)));

  assert_mid_beat_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |-> !ras_n);

  assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= HI_MIN));

  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n));
endmodule

bind dram_page_burst dram_page_burst_chk #(.ADDR_W(ADDR_W), .PRE_CYC(PRE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_row(req_row), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .addr(dram_addr),
  .rsp_valid(rsp_valid), .rsp_last(rsp_last)
);

// File: tb/dram_page_burst_tb.sv
module dram_page_burst_tb;
  localparam int AW   = 14;
  localparam int DW   = 16;
  localparam int BL   = 4;
  localparam int LEAD = 5;
  localparam int PRE  = 3;
  localparam int REFI = 60;
  localparam int NCOL = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dval(input int r, input int c);
    int v;
    v = ((r % NCOL) * 7) ^ ((c % NCOL) << 2) ^ 32'h5A3C;
    return DW'(v);
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_inst
    localparam int BEAT = (g == 1) ? 2 : 3;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_row = '0;
    logic [AW-1:0] req_col = '0;
    logic          req_ready, ras_n, cas_n, we_n, rsp_valid, rsp_last;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq, rsp_data;
    logic [1:0]    rsp_beat;

    dram_page_burst #(
      .ADDR_W(AW), .DATA_W(DW), .BURST_LEN(BL), .EDO_MODE(g == 1),
      .LEAD_CYC(LEAD), .FPM_BEAT_CYC(3), .EDO_BEAT_CYC(2),
      .PRE_CYC(PRE), .REF_INTERVAL(REFI)
    ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_row(req_row), .req_col(req_col), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
      .dram_we_n(we_n), .dram_addr(addr), .dram_dq(dq), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_beat(rsp_beat), .rsp_last(rsp_last)
    );

    logic [AW-1:0] m_row = '0;
    logic [AW-1:0] m_col = '0;
    logic          m_out = 1'b0;
    always @(negedge ras_n) m_row = addr;
    always @(negedge cas_n) begin m_col = addr; m_out = 1'b1; end
    always @(posedge cas_n) if (g == 0) m_out = 1'b0;
    assign dq = m_out ? dval(int'(m_row), int'(m_col)) : '0;

    int nf = 0, nc = 0, ncr = 0, nv = 0;
    int rf_t[256], rf_row[256];
    int cas_t[512], cas_col[512], cr_addr[512];
    int rv_t[512], rv_d[512], rv_b[512], rv_l[512];
    int hi_len = 100, lo_len = 0, cas_in = 0, ref_exp = 0;
    bit pr = 1'b1, pcs = 1'b1;

    always @(negedge clk) if (rst_n) begin
      if (ras_n) begin
        if (!pr) begin
          if (cas_in == 0) begin
            chk(rf_row[nf-1] == ref_exp, "R9 refresh row", rf_row[nf-1], ref_exp);
            chk(lo_len == LEAD - 1, "R9 refresh strobe width", lo_len, LEAD - 1);
            ref_exp = (ref_exp + 1) % NCOL;
          end else begin
            chk(cas_in == BL, "R6 column strobes per row", cas_in, BL);
            chk(lo_len == LEAD + (BL - 1) * BEAT - 1, "R6 row open width", lo_len,
                LEAD + (BL - 1) * BEAT - 1);
          end
          hi_len = 0;
        end
        hi_len++;
      end else begin
        if (pr) begin
          chk(hi_len >= PRE + 1, "R8 precharge", hi_len, PRE + 1);
          rf_t[nf] = cyc; rf_row[nf] = int'(addr); nf++;
          lo_len = 0; cas_in = 0;
        end
        lo_len++;
      end
      if (pcs && !cas_n) begin
        cas_t[nc] = cyc; cas_col[nc] = int'(addr); nc++; cas_in++;
        chk(we_n == 1'b1, "R12 write enable", we_n, 1);
      end
      if (!pcs && cas_n) begin cr_addr[ncr] = int'(addr); ncr++; end
      if (rsp_valid) begin
        rv_t[nv] = cyc; rv_d[nv] = int'(rsp_data); rv_b[nv] = int'(rsp_beat);
        rv_l[nv] = int'(rsp_last); nv++;
      end
      pr = ras_n; pcs = cas_n;
    end

    task automatic send(input int row, input int col, output int acc);
      req_row = AW'(row); req_col = AW'(col); req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      acc = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
    endtask

    task automatic burst_check(input int acc, input int row, input int col,
                               input int vi, input int ci, input int cri, input int fi);
      while (nv < vi + BL) @(negedge clk);
      chk(rf_t[fi] == acc + 1, "R3 row strobe after accept", rf_t[fi], acc + 1);
      chk(rf_row[fi] == row, "R2 row address", rf_row[fi], row);
      for (int k = 0; k < BL; k++) begin
        int et;
        et = acc + LEAD + k * BEAT;
        if (k == 0) chk(rv_t[vi] == et, "R3 first word lead", rv_t[vi], et);
        else if (g == 0) chk(rv_t[vi+k] == et, "R4 fast-page beat time", rv_t[vi+k], et);
        else chk(rv_t[vi+k] == et, "R5 overlapped beat time", rv_t[vi+k], et);
        chk(cas_t[ci+k] == et - 1, "R2 column strobe time", cas_t[ci+k], et - 1);
        chk(cas_col[ci+k] == (col + k) % NCOL, "R2 column address", cas_col[ci+k],
            (col + k) % NCOL);
        chk(rv_d[vi+k] == int'(dval(row, col + k)), "R7 data", rv_d[vi+k],
            int'(dval(row, col + k)));
        chk(rv_b[vi+k] == k, "R7 beat index", rv_b[vi+k], k);
        chk(rv_l[vi+k] == int'(k == BL - 1), "R7 last flag", rv_l[vi+k], int'(k == BL - 1));
        if (k < BL - 1) begin
          if (g == 0) chk(cr_addr[cri+k] == (col + k) % NCOL, "R4 address held at strobe rise",
                          cr_addr[cri+k], (col + k) % NCOL);
          else chk(cr_addr[cri+k] == (col + k + 1) % NCOL, "R5 next address at strobe rise",
                   cr_addr[cri+k], (col + k + 1) % NCOL);
        end
      end
    endtask

    task automatic run();
      int acc, acc2, end3, row, col;
      chk(ras_n && cas_n && we_n && !rsp_valid && req_ready, "R1 reset state",
          {ras_n, cas_n, we_n, rsp_valid, req_ready}, 5'b11101);
      while (nf < 1) @(negedge clk);
      chk(rf_t[0] == REFI + 2, "R9 idle refresh time", rf_t[0], REFI + 2);
      chk(!req_ready, "R10 ready low during refresh", req_ready, 0);
      send(100, 8, acc);
      chk(acc == REFI + 1 + LEAD + PRE, "R10 deferred accept", acc, REFI + 1 + LEAD + PRE);
      burst_check(acc, 100, 8, nv, nc, ncr, nf);
      send(16000, NCOL - 2, acc2);
      chk(acc2 == acc + LEAD + (BL - 1) * BEAT + PRE, "R8 back-to-back accept", acc2,
          acc + LEAD + (BL - 1) * BEAT + PRE);
      burst_check(acc2, 16000, NCOL - 2, nv, nc, ncr, nf);
      while (cyc != 2 * REFI - 6) @(negedge clk);
      send(777, 40, acc);
      chk(acc == 2 * REFI - 5, "R3 idle accept", acc, 2 * REFI - 5);
      end3 = acc + LEAD + (BL - 1) * BEAT;
      begin
        int vi, ci, cri, fi;
        vi = nv; ci = nc; cri = ncr; fi = nf;
        send(4321, 1000, acc2);
        burst_check(acc, 777, 40, vi, ci, cri, fi);
      end
      chk(rf_t[nf-1] == end3 + PRE + 1, "R11 refresh after burst", rf_t[nf-1], end3 + PRE + 1);
      chk(acc2 == end3 + PRE + LEAD + PRE, "R10 request after mid-burst refresh", acc2,
          end3 + PRE + LEAD + PRE);
      burst_check(acc2, 4321, 1000, nv, nc, ncr, nf);
      for (int i = 0; i < 48; i++) begin
        row = (i * 1237 + g * 91) % NCOL;
        col = (i % 8 == 0) ? NCOL - 3 + (i / 8) % 3 : (i * 341 + 5) % NCOL;
        send(row, col, acc);
        burst_check(acc, row, col, nv, nc, ncr, nf);
      end
    endtask
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      g_inst[0].run();
      g_inst[1].run();
    join
    repeat (5) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    report();
    $finish;
  end
endmodule